// File: doc/BRIEF.md
# Broadcast Coherence Node Array

This block holds a row of identical cache-line ownership trackers, one per node, each sitting in one of three states: Invalid (ST_INV), Shared (ST_SHR) or Modified (ST_MOD). Every cycle one command is broadcast to the whole row: an operation code and a target node index. When the command is accepted, every node computes its next state at the same clock edge. The addressed node follows one rule and every other node follows another. No data, addresses or arbitration are modelled. The block only tracks who may read and who owns the line exclusively.

The node machine has three named states and these named transitions. FILL takes ST_INV to ST_SHR on a read aimed at the node. DOWNGRADE takes ST_MOD to ST_SHR on a read aimed at another node. CLAIM takes any state to ST_MOD on a write aimed at the node. INVALIDATE takes any state to ST_INV on a write aimed elsewhere. DROP takes any state to ST_INV on an evict aimed at the node. All other combinations are HOLD.

The full state vector is reported on one port. A combinational flag warns if more than one node is ever in ST_MOD.

Top module: `coh_node_array`

## Requirements
- R1: State codes are ST_INV=0, ST_SHR=1 and ST_MOD=2. Node i is reported in node_state[2i+1:2i]. While rst_n is low, and on the first cycle after it, every node reads ST_INV.
- R2: For a read (upd_op=0) aimed at node i, node i goes from ST_INV to ST_SHR. If node i is in ST_SHR or ST_MOD, it keeps that state.
- R3: For a read aimed at another node, a node in ST_MOD goes to ST_SHR. A node in ST_SHR or ST_INV keeps its state.
- R4: For a write (upd_op=1), the addressed node goes to ST_MOD from any state, and every other node goes to ST_INV.
- R5: For an evict (upd_op=2), the addressed node goes to ST_INV from any state, and every other node keeps its state.
- R6: When upd_vld is low, no node changes state, whatever the op and target are.
- R7: Op code 3 is a no-operation, and no node changes state.
- R8: A target value of NODES or above addresses no node. Every node then applies its non-target rule: a read downgrades ST_MOD, a write invalidates all nodes, and an evict changes nothing.
- R9: multi_mod_err is high exactly when two or more nodes are in ST_MOD. It stays low under any legal command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all nodes |
| rst_n | input | 1 | Active-low synchronous reset to ST_INV |
| upd_vld | input | 1 | Command valid. When low, all nodes hold |
| upd_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| upd_tgt | input | SEL_W | Target node index. Values of NODES or above address no node |
| node_state | output | 2*NODES | Packed per-node state codes |
| multi_mod_err | output | 1 | High when more than one node is in ST_MOD |

## Verification
The bench builds the array with NODES=4. This makes SEL_W three bits wide, so targets 4 to 7 can be driven and the unaddressed case of R8 is reachable through the ports. Four nodes give 81 state tuples. A long random run with a fixed seed reaches every legal tuple and every transition kind. Directed sequences first place one node in ST_MOD and then hit it with peer reads, out-of-range writes and stalled commands.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_MOD = 2'd2
    } node_st_t;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_WR  = 2'd1,
        CMD_EV  = 2'd2,
        CMD_NOP = 2'd3
    } cmd_t;

endpackage

// File: rtl/coh_tgt_dec.sv
module coh_tgt_dec #(
    parameter int NODES = 4,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] tgt_i,
    output logic [NODES-1:0] hit_o
);
    // Out-of-range targets match no lane (R8).
    for (genvar g = 0; g < NODES; g++) begin : g_lane
        assign hit_o[g] = (tgt_i == SEL_W'(g));
    end
endmodule

// File: rtl/coh_node.sv
module coh_node
    import coh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upd_vld,
    input  logic     is_tgt,
    input  cmd_t     cmd,
    output node_st_t st_o
);
    node_st_t cur_st;
    node_st_t nxt_st;

    // State register: all nodes share this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_st <= ST_INV;
        else if (upd_vld)
            cur_st <= nxt_st;
    end

    // Transition rules
    always_comb begin
        nxt_st = cur_st;
        unique case (cmd)
            CMD_RD: begin
                unique case (cur_st)
                    ST_INV:  nxt_st = is_tgt ? ST_SHR : ST_INV;  // FILL
                    ST_SHR:  nxt_st = ST_SHR;
                    ST_MOD:  nxt_st = is_tgt ? ST_MOD : ST_SHR;  // DOWNGRADE
                    default: nxt_st = ST_INV;
                endcase
            end
            CMD_WR:  nxt_st = is_tgt ? ST_MOD : ST_INV;          // CLAIM / INVALIDATE
            CMD_EV:  nxt_st = is_tgt ? ST_INV : cur_st;          // DROP
            default: nxt_st = cur_st;                            // HOLD
        endcase
    end

    // Output process
    always_comb st_o = cur_st;
endmodule

// File: rtl/coh_mod_watch.sv
module coh_mod_watch
    import coh_pkg::*;
#(
    parameter int NODES = 4
) (
    input  logic [2*NODES-1:0] st_vec_i,
    output logic               err_o
);
    localparam int CNT_W = $clog2(NODES + 1);

    logic [CNT_W-1:0] n_mod;

    always_comb begin
        n_mod = '0;
        for (int k = 0; k < NODES; k++) begin
            if (st_vec_i[2*k +: 2] == ST_MOD)
                n_mod = n_mod + CNT_W'(1);
        end
        err_o = (n_mod > CNT_W'(1));
    end
endmodule

// File: rtl/coh_node_array.sv
module coh_node_array
    import coh_pkg::*;
#(
    parameter int  NODES = 4,
    localparam int SEL_W = $clog2(NODES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_vld,
    input  logic [1:0]         upd_op,
    input  logic [SEL_W-1:0]   upd_tgt,
    output logic [2*NODES-1:0] node_state,
    output logic               multi_mod_err
);
    logic [NODES-1:0] hit;
    cmd_t             cmd;

    assign cmd = cmd_t'(upd_op);

    coh_tgt_dec #(.NODES(NODES), .SEL_W(SEL_W)) u_dec (
        .tgt_i (upd_tgt),
        .hit_o (hit)
    );

    for (genvar g = 0; g < NODES; g++) begin : g_node
        node_st_t st;
        coh_node u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_vld (upd_vld),
            .is_tgt  (hit[g]),
            .cmd     (cmd),
            .st_o    (st)
        );
        assign node_state[2*g +: 2] = st;
    end

    coh_mod_watch #(.NODES(NODES)) u_watch (
        .st_vec_i (node_state),
        .err_o    (multi_mod_err)
    );
endmodule

// File: rtl/coh_node_array_chk.sv
module coh_node_array_chk #(
    parameter int NODES = 4,
    parameter int SEL_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_vld,
    input logic [1:0]         upd_op,
    input logic [SEL_W-1:0]   upd_tgt,
    input logic [2*NODES-1:0] node_state,
    input logic               multi_mod_err
);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_vld |=> $stable(node_state));

    p_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && upd_op == 2'd3) |=> $stable(node_state));

    p_single_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !multi_mod_err);

    for (genvar g = 0; g < NODES; g++) begin : g_chk
        p_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_vld && upd_op == 2'd1 && upd_tgt == SEL_W'(g))
            |=> node_state[2*g +: 2] == 2'd2);

        p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_vld && upd_op == 2'd2 && upd_tgt == SEL_W'(g))
            |=> node_state[2*g +: 2] == 2'd0);

        p_downgrade_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_vld && upd_op == 2'd0 && upd_tgt != SEL_W'(g)
             && node_state[2*g +: 2] == 2'd2)
            |=> node_state[2*g +: 2] == 2'd1);

        p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
            node_state[2*g +: 2] != 2'd3);
    end
endmodule

bind coh_node_array coh_node_array_chk #(.NODES(NODES), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/coh_node_array_tb.sv
module coh_node_array_tb;
    localparam int NODES   = 4;
    localparam int SEL_W   = $clog2(NODES) + 1;
    localparam int CLK_PER = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               upd_vld = 1'b0;
    logic [1:0]         upd_op = 2'd3;
    logic [SEL_W-1:0]   upd_tgt = '0;
    logic [2*NODES-1:0] node_state;
    logic               multi_mod_err;

    int total = 0;
    int bad   = 0;
    logic [1:0] exp_st [NODES];

    always #(CLK_PER/2) clk = ~clk;

    coh_node_array #(.NODES(NODES)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_op(upd_op),
        .upd_tgt(upd_tgt), .node_state(node_state), .multi_mod_err(multi_mod_err)
    );

    function automatic logic [1:0] ref_next(logic [1:0] cur, logic hit, logic [1:0] op);
        case (op)
            2'd0: if (hit) return (cur == 2'd0) ? 2'd1 : cur;
                  else     return (cur == 2'd2) ? 2'd1 : cur;
            2'd1: return hit ? 2'd2 : 2'd0;
            2'd2: return hit ? 2'd0 : cur;
            default: return cur;
        endcase
    endfunction

    function automatic string req_of(logic vld, logic [1:0] op, logic [SEL_W-1:0] tgt);
        if (!vld)              return "R6";
        if (op == 2'd3)        return "R7";
        if (tgt >= NODES)      return "R8";
        if (op == 2'd0)        return "R2/R3";
        if (op == 2'd1)        return "R4";
        return "R5";
    endfunction

    task automatic compare(string req);
        int nm = 0;
        for (int k = 0; k < NODES; k++) begin
            total++;
            if (node_state[2*k +: 2] != exp_st[k]) begin
                bad++;
                $display("FAIL %s node %0d state act=%0d exp=%0d", req, k,
                         node_state[2*k +: 2], exp_st[k]);
            end
            if (exp_st[k] == 2'd2) nm++;
        end
        total++;
        if (multi_mod_err !== (nm > 1)) begin
            bad++;
            $display("FAIL R9 err act=%0b exp=%0b", multi_mod_err, nm > 1);
        end
    endtask

    task automatic step(logic vld, logic [1:0] op, logic [SEL_W-1:0] tgt);
        @(negedge clk);
        upd_vld = vld; upd_op = op; upd_tgt = tgt;
        if (vld)
            for (int k = 0; k < NODES; k++)
                exp_st[k] = ref_next(exp_st[k], tgt == SEL_W'(k), op);
        @(posedge clk); #1;
        compare(req_of(vld, op, tgt));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int seed = 32'h5eed_c0de;
        void'($urandom(seed));
        for (int k = 0; k < NODES; k++) exp_st[k] = 2'd0;
        repeat (3) @(posedge clk);
        #1 compare("R1");                 // reset state, all ST_INV
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 compare("R1");

        // Directed corner cases
        step(1, 2'd0, 3'd1);   // R2 FILL node1
        step(1, 2'd0, 3'd1);   // R2 hold shared
        step(1, 2'd1, 3'd2);   // R4 claim node2, node1 invalidated
        step(1, 2'd0, 3'd2);   // R2 owner read keeps ST_MOD
        step(0, 2'd1, 3'd0);   // R6 stalled write
        step(1, 2'd3, 3'd0);   // R7 no-op
        step(1, 2'd0, 3'd0);   // R3 downgrade node2
        step(1, 2'd1, 3'd3);   // R4 claim node3
        step(1, 2'd2, 3'd6);   // R8 evict to nobody
        step(1, 2'd0, 3'd5);   // R8 read to nobody downgrades
        step(1, 2'd1, 3'd0);   // R4
        step(1, 2'd1, 3'd7);   // R8 write to nobody clears all
        step(1, 2'd1, 3'd1);
        step(1, 2'd2, 3'd1);   // R5 drop owner
        step(1, 2'd0, 3'd0);
        step(1, 2'd2, 3'd3);   // R5 peers hold

        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            logic v = ($urandom % 10) != 0;
            step(v, 2'($urandom % 4), SEL_W'($urandom % (1 << SEL_W)));
        end

        // Reset from a busy state
        step(1, 2'd1, 3'd2);
        @(negedge clk) rst_n = 1'b0;
        for (int k = 0; k < NODES; k++) exp_st[k] = 2'd0;
        @(posedge clk); #1 compare("R1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule